// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits behind the parallel bus of a NOR-style flash device and reads every write cycle (word address, 16-bit data, write strobe) as part of a command sequence. It keeps track of the device's operating mode: read-array, autoselect (identification), program set-up and unlock-bypass. When a program sequence completes, it issues a single-cycle program request that carries the captured target address and data. It also chooses the word driven back on reads. In read-array mode that word comes from the array. In autoselect mode it is an identification value.

Command bytes are taken from data bits 7:0. Unlock and command addresses are matched on the low 11 address bits. A standard program takes four writes. After the device enters unlock-bypass, a program takes two writes and no unlock prefix, and the device stays in bypass until the two-write bypass exit. The manufacturer and device codes are parameters. The per-sector protect bits and the burst-mode flag are inputs.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 2'b00 (read-array), `prog_req` is 0 and `rd_data` equals `array_rdata`. The mode encoding is 00 read-array, 01 autoselect, 10 program set-up, 11 unlock-bypass.
- R2: The device enters autoselect on this sequence of writes: AAh at 555h, then 55h at 2AAh, then 90h at 555h. `mode` reads 01 in the cycle after the third write. The two unlock writes alone leave `mode` at 00.
- R3: In autoselect, a read with address bits 7:0 equal to 00h returns `MFR_CODE`, and 01h returns `DEV_CODE`. This holds for any upper address bits and for any number of reads.
- R4: In autoselect, a read with address bits 7:0 equal to 02h returns 0001h if `sect_prot[s]` is set and 0000h otherwise. Here s is the sector number in address bits 11:10.
- R5: In autoselect, offset 03h returns 0001h when `burst_mode` is 1 and 0000h when it is 0. Every other offset returns 0000h.
- R6: In autoselect, any write whose data bits 7:0 are not F0h leaves the mode unchanged and raises no program request. A write of F0h returns the device to read-array.
- R7: A standard program is AAh at 555h, 55h at 2AAh, then A0h at 555h, after which `mode` reads 10. The fourth write, at any address, raises `prog_req` for exactly one cycle, in the cycle after that write. In that cycle `prog_addr` and `prog_data` hold the fourth write's address and data, and `mode` is back to 00.
- R8: In read-array mode, a write that does not match the expected next unlock or command write (wrong data or wrong address) returns the sequence to its start with no request. The rest of the sequence written afterwards then has no effect.
- R9: AAh at 555h, 55h at 2AAh, then 20h at 555h enters unlock-bypass (`mode` 11). In bypass, a write of A0h at any address followed by a write of address and data raises one `prog_req` with that address and data, and the device stays in bypass.
- R10: In bypass, 90h followed by 00h (addresses ignored) returns the device to read-array. Any other write, including F0h, the unlock writes, or a non-00h write after 90h, leaves the device in bypass and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle while high |
| addr | input | 12 | Word address for writes and reads |
| wdata | input | 16 | Write data |
| sect_prot | input | 4 | Protect flag per sector |
| burst_mode | input | 1 | 1 when the device is in synchronous burst mode |
| array_rdata | input | 16 | Word read from the array |
| mode | output | 2 | Current mode |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | 12 | Address of the requested program |
| prog_data | output | 16 | Data of the requested program |
| rd_data | output | 16 | Word to drive on a read |

## Verification
A wrong internal state shows up in the cycle right after the write that caused it. It appears as a wrong `mode` code, as identification words in place of array data on `rd_data`, or as a `prog_req` pulse that is missing or extra. A sequence position that should have been dropped but was kept only shows later, when the remaining writes of a sequence advance the mode. So every broken prefix is followed by the rest of the sequence, and the bench checks that the mode stays at read-array. Autoselect readback is swept over every address and every combination of protect bits and burst flag, because a mux error appears only at particular offset and sector pairs.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        S_READ  = 3'd0,
        S_UNLK1 = 3'd1,
        S_UNLK2 = 3'd2,
        S_AUTO  = 3'd3,
        S_PSET  = 3'd4,
        S_BYP   = 3'd5,
        S_BPROG = 3'd6,
        S_BRST  = 3'd7
    } seq_state_e;

    typedef enum logic [1:0] {
        M_READ = 2'd0,
        M_AUTO = 2'd1,
        M_PSET = 2'd2,
        M_BYP  = 2'd3
    } mode_e;

    localparam logic [7:0] CMD_UNLK1  = 8'hAA;
    localparam logic [7:0] CMD_UNLK2  = 8'h55;
    localparam logic [7:0] CMD_AUTO   = 8'h90;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_BYPASS = 8'h20;
    localparam logic [7:0] CMD_RESET  = 8'hF0;
    localparam logic [7:0] CMD_BEXIT2 = 8'h00;

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int CMD_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [1:0]        mode,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data
);

    localparam logic [CMD_AW-1:0] ADR_FIRST  = CMD_AW'(12'h555);
    localparam logic [CMD_AW-1:0] ADR_SECOND = CMD_AW'(12'h2AA);

    typedef struct packed {
        seq_state_e        st;
        logic              req;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdata;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic [7:0] cmd;
    logic       at_first;
    logic       at_second;

    assign cmd       = wdata[7:0];
    assign at_first  = (addr[CMD_AW-1:0] == ADR_FIRST);
    assign at_second = (addr[CMD_AW-1:0] == ADR_SECOND);

    always_comb begin
        seq_d     = seq_q;
        seq_d.req = 1'b0;
        if (wr_en) begin
            unique case (seq_q.st)
                S_READ: begin
                    seq_d.st = (at_first && cmd == CMD_UNLK1) ? S_UNLK1 : S_READ;
                end
                S_UNLK1: begin
                    seq_d.st = (at_second && cmd == CMD_UNLK2) ? S_UNLK2 : S_READ;
                end
                S_UNLK2: begin
                    if (at_first && cmd == CMD_AUTO)        seq_d.st = S_AUTO;
                    else if (at_first && cmd == CMD_PROG)   seq_d.st = S_PSET;
                    else if (at_first && cmd == CMD_BYPASS) seq_d.st = S_BYP;
                    else                                    seq_d.st = S_READ;
                end
                S_AUTO: begin
                    if (cmd == CMD_RESET) seq_d.st = S_READ;
                end
                S_PSET: begin
                    seq_d.st    = S_READ;
                    seq_d.req   = 1'b1;
                    seq_d.paddr = addr;
                    seq_d.pdata = wdata;
                end
                S_BYP: begin
                    if (cmd == CMD_PROG)      seq_d.st = S_BPROG;
                    else if (cmd == CMD_AUTO) seq_d.st = S_BRST;
                end
                S_BPROG: begin
                    seq_d.st    = S_BYP;
                    seq_d.req   = 1'b1;
                    seq_d.paddr = addr;
                    seq_d.pdata = wdata;
                end
                S_BRST: begin
                    seq_d.st = (cmd == CMD_BEXIT2) ? S_READ : S_BYP;
                end
                default: seq_d.st = S_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: S_READ, req: 1'b0, paddr: '0, pdata: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        unique case (seq_q.st)
            S_AUTO:                 mode = M_AUTO;
            S_PSET:                 mode = M_PSET;
            S_BYP, S_BPROG, S_BRST: mode = M_BYP;
            default:                mode = M_READ;
        endcase
    end

    assign prog_req  = seq_q.req;
    assign prog_addr = seq_q.paddr;
    assign prog_data = seq_q.pdata;

endmodule

// File: rtl/fcd_idmux.sv
module fcd_idmux #(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 16,
    parameter int          SECT_W   = 2,
    parameter int          OFF_W    = 8,
    parameter logic [15:0] MFR_CODE = 16'h0001,
    parameter logic [15:0] DEV_CODE = 16'h2203
) (
    input  logic                   id_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [(1<<SECT_W)-1:0] sect_prot,
    input  logic                   burst_mode,
    input  logic [DATA_W-1:0]      array_rdata,
    output logic [DATA_W-1:0]      rd_data
);

    localparam int NSECT = 1 << SECT_W;

    logic [OFF_W-1:0]  offset;
    logic [SECT_W-1:0] sector;
    logic              prot_bit;
    logic [DATA_W-1:0] id_word;

    assign offset = addr[OFF_W-1:0];
    assign sector = addr[ADDR_W-1 -: SECT_W];

    generate
        if (NSECT == 1) begin : g_one_sector
            assign prot_bit = sect_prot[0];
        end else begin : g_many_sectors
            assign prot_bit = sect_prot[sector];
        end
    endgenerate

    always_comb begin
        unique case (offset)
            OFF_W'(0): id_word = DATA_W'(MFR_CODE);
            OFF_W'(1): id_word = DATA_W'(DEV_CODE);
            OFF_W'(2): id_word = DATA_W'(prot_bit);
            OFF_W'(3): id_word = DATA_W'(burst_mode);
            default:   id_word = '0;
        endcase
    end

    assign rd_data = id_en ? id_word : array_rdata;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 16,
    parameter int          SECT_W   = 2,
    parameter logic [15:0] MFR_CODE = 16'h0001,
    parameter logic [15:0] DEV_CODE = 16'h2203
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [(1<<SECT_W)-1:0] sect_prot,
    input  logic                   burst_mode,
    input  logic [DATA_W-1:0]      array_rdata,
    output logic [1:0]             mode,
    output logic                   prog_req,
    output logic [ADDR_W-1:0]      prog_addr,
    output logic [DATA_W-1:0]      prog_data,
    output logic [DATA_W-1:0]      rd_data
);

    localparam int CMD_AW = 11;

    logic [1:0] mode_w;

    fcd_seq #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CMD_AW(CMD_AW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .mode     (mode_w),
        .prog_req (prog_req),
        .prog_addr(prog_addr),
        .prog_data(prog_data)
    );

    fcd_idmux #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SECT_W  (SECT_W),
        .OFF_W   (8),
        .MFR_CODE(MFR_CODE),
        .DEV_CODE(DEV_CODE)
    ) u_idmux (
        .id_en      (mode_w == M_AUTO),
        .addr       (addr),
        .sect_prot  (sect_prot),
        .burst_mode (burst_mode),
        .array_rdata(array_rdata),
        .rd_data    (rd_data)
    );

    assign mode = mode_w;

endmodule

// File: rtl/flash_cmd_decoder_checker.sv
module flash_cmd_decoder_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic [1:0]        mode,
    input logic              prog_req,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] array_rdata
);

    a_r1_read_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> (rd_data == array_rdata));

    a_r2_auto_entry_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && $past(mode) != 2'd1) |-> ($past(wr_en) && $past(wdata[7:0]) == 8'h90));

    a_r6_auto_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && !(wr_en && wdata[7:0] == 8'hF0)) |=> (mode == 2'd1));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    a_r7_req_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> $past(wr_en));

    a_r10_bypass_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && !(wr_en && wdata[7:0] == 8'h00)) |=> (mode == 2'd3));

    a_r10_bypass_exit_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |=> (mode == 2'd3 || mode == 2'd0));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_checker #(.DATA_W(DATA_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wdata      (wdata),
    .mode       (mode),
    .prog_req   (prog_req),
    .rd_data    (rd_data),
    .array_rdata(array_rdata)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

    localparam logic [15:0] MFR = 16'h0001;
    localparam logic [15:0] DEV = 16'h2203;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [3:0]  sect_prot = '0;
    logic        burst_mode = 1'b0;
    logic [15:0] array_rdata = 16'h1234;
    logic [1:0]  mode;
    logic        prog_req;
    logic [11:0] prog_addr;
    logic [15:0] prog_data;
    logic [15:0] rd_data;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flash_cmd_decoder #(.MFR_CODE(MFR), .DEV_CODE(DEV)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .sect_prot(sect_prot), .burst_mode(burst_mode), .array_rdata(array_rdata),
        .mode(mode), .prog_req(prog_req), .prog_addr(prog_addr),
        .prog_data(prog_data), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] exp_id(input logic [11:0] a, input logic [3:0] sp, input logic b);
        int off = int'(a[7:0]);
        int sec = int'(a[11:10]);
        if (off == 0) return MFR;
        if (off == 1) return DEV;
        if (off == 2) return 16'((sp >> sec) & 1);
        if (off == 3) return 16'(b);
        return 16'h0000;
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", 32'(mode), 0);
        chk("R1 prog_req", 32'(prog_req), 0);
        chk("R1 rd_data", 32'(rd_data), 32'h1234);

        // R2 autoselect entry
        wr(12'h555, 16'h00AA); chk("R2 after unlock1", 32'(mode), 0);
        wr(12'h2AA, 16'h0055); chk("R2 after unlock2", 32'(mode), 0);
        wr(12'h555, 16'h0090); chk("R2 enter autoselect", 32'(mode), 1);

        // R3 R4 R5 sweep over protect patterns, burst flag, sectors, offsets
        for (int sp = 0; sp < 16; sp++) begin
            for (int b = 0; b < 2; b++) begin
                for (int s = 0; s < 4; s++) begin
                    for (int o = 0; o < 6; o++) begin
                        logic [11:0] a;
                        a = 12'((s << 10) | (o == 5 ? 8'hFF : o));
                        sect_prot = 4'(sp); burst_mode = 1'(b); addr = a;
                        #1;
                        if (o < 2)       chk("R3 id code", 32'(rd_data), 32'(exp_id(a, 4'(sp), 1'(b))));
                        else if (o == 2) chk("R4 protect", 32'(rd_data), 32'(exp_id(a, 4'(sp), 1'(b))));
                        else             chk("R5 burst/other", 32'(rd_data), 32'(exp_id(a, 4'(sp), 1'(b))));
                    end
                end
            end
        end
        sect_prot = 4'b1010; burst_mode = 1'b1;
        for (int a = 0; a < 4096; a++) begin
            addr = 12'(a);
            #1;
            chk("R5 full address sweep", 32'(rd_data), 32'(exp_id(12'(a), 4'b1010, 1'b1)));
        end

        // R6 writes other than F0 are ignored in autoselect
        wr(12'h555, 16'h00AA); chk("R6 AA ignored", 32'(mode), 1);
        wr(12'h000, 16'h00A0); chk("R6 A0 ignored", 32'(mode), 1);
        chk("R6 no request", 32'(prog_req), 0);
        wr(12'h123, 16'h0000); chk("R6 00 ignored", 32'(mode), 1);
        addr = 12'h000; #1;
        chk("R6 still reads id", 32'(rd_data), 32'(MFR));
        wr(12'h7FF, 16'h00F0); chk("R6 reset exits", 32'(mode), 0);
        addr = 12'h000; #1;
        chk("R6 array after exit", 32'(rd_data), 32'h1234);

        // R7 standard program
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055);
        wr(12'h555, 16'h00A0); chk("R7 setup mode", 32'(mode), 2);
        wr(12'hABC, 16'h5A5A);
        chk("R7 req", 32'(prog_req), 1);
        chk("R7 addr", 32'(prog_addr), 32'hABC);
        chk("R7 data", 32'(prog_data), 32'h5A5A);
        chk("R7 back to read", 32'(mode), 0);
        @(negedge clk);
        chk("R7 one cycle", 32'(prog_req), 0);

        // R8 broken prefixes at each step, wrong data and wrong address
        for (int step = 0; step < 3; step++) begin
            for (int kind = 0; kind < 2; kind++) begin
                logic [11:0] ga [3];
                logic [15:0] gd [3];
                ga[0] = 12'h555; gd[0] = 16'h00AA;
                ga[1] = 12'h2AA; gd[1] = 16'h0055;
                ga[2] = 12'h555; gd[2] = 16'h0090;
                for (int k = 0; k < step; k++) wr(ga[k], gd[k]);
                if (kind == 0) wr(ga[step], 16'h0033);
                else           wr(ga[step] ^ 12'h001, gd[step]);
                chk("R8 broken to read", 32'(mode), 0);
                chk("R8 no request", 32'(prog_req), 0);
                for (int k = step + 1; k < 3; k++) wr(ga[k], gd[k]);
                chk("R8 tail has no effect", 32'(mode), 0);
            end
        end

        // R9 unlock bypass programs
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055);
        wr(12'h555, 16'h0020); chk("R9 enter bypass", 32'(mode), 3);
        for (int i = 0; i < 3; i++) begin
            wr(12'(i * 12'h155), 16'h00A0);
            chk("R9 setup no req", 32'(prog_req), 0);
            wr(12'(12'h100 + i * 7), 16'(16'hC000 + i));
            chk("R9 req", 32'(prog_req), 1);
            chk("R9 addr", 32'(prog_addr), 32'(12'h100 + i * 7));
            chk("R9 data", 32'(prog_data), 32'(16'hC000 + i));
            chk("R9 stays bypass", 32'(mode), 3);
            @(negedge clk);
            chk("R9 one cycle", 32'(prog_req), 0);
        end

        // R10 invalid writes in bypass, then exit
        wr(12'h000, 16'h00F0); chk("R10 F0 ignored", 32'(mode), 3);
        wr(12'h555, 16'h00AA); chk("R10 AA ignored", 32'(mode), 3);
        chk("R10 no request", 32'(prog_req), 0);
        wr(12'h2AA, 16'h0055); chk("R10 55 ignored", 32'(mode), 3);
        wr(12'h000, 16'h0090); chk("R10 exit half", 32'(mode), 3);
        wr(12'h000, 16'h0012); chk("R10 bad exit stays", 32'(mode), 3);
        chk("R10 bad exit no request", 32'(prog_req), 0);
        wr(12'h000, 16'h00A0); wr(12'h042, 16'hBEEF);
        chk("R10 program still works", 32'(prog_data), 32'hBEEF);
        wr(12'h3FF, 16'h0090); wr(12'h111, 16'h0000);
        chk("R10 exit to read", 32'(mode), 0);
        addr = 12'h000; #1;
        chk("R10 array reads", 32'(rd_data), 32'h1234);
        wr(12'h042, 16'h1234);
        chk("R10 plain write no request", 32'(prog_req), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule